// File: doc/BRIEF.md
# Framed Program Loader with Checked Commit

This block sits between a serial receiver and an instruction memory. It takes a stream of received bytes and splits it into frames at zero bytes. Each frame is decoded with COBS (consistent overhead byte stuffing) and checked against a CRC-8 trailer. It then acts on the message inside. A load message carries a program as 32-bit words, and the block writes those words into the instruction memory from address 0 upward. A start message raises a one-cycle start pulse toward the execution engine.

Nothing reaches the memory or the engine until a frame has been fully checked. Payload bytes first go into an internal staging store. Only when the delimiter arrives, with a zero CRC residue and a legal length, does the block copy the staged words to memory, one word per cycle. A damaged frame leaves the previous program untouched.

The block shares one clock domain with the engine and has no FIFO. While a copy is in progress, bytes on the receive input are dropped, so the host must pace the frames. The controller has four states:
- HUNT waits for the first code byte of a frame.
- BODY decodes the frame.
- SKIP discards the rest of an oversize frame up to its delimiter.
- COMMIT copies the staged words.

The transitions are:
- HUNT→BODY on a code byte.
- BODY→COMMIT on a delimiter that closes a good load frame with at least one word.
- BODY→HUNT on any other delimiter.
- BODY→SKIP on overflow.
- SKIP→HUNT on a delimiter.
- COMMIT→HUNT after the last word.

Top module: `cobs_prog_loader`

## Requirements
- R1: After reset, `ram_we` and `start_pulse` are low and stay low until a valid frame completes.
- R2: A zero input byte ends a frame. A non-zero code byte k is followed by k-1 data bytes, and an implied zero is decoded after them, unless k is 0xFF or the delimiter follows directly.
- R3: A frame whose first decoded byte is 0x01 (load), with a good CRC, writes its payload as little-endian 32-bit words. Payload byte 0 goes to bits 7:0. The writes come one per cycle, the first in the cycle after the delimiter is sampled.
- R4: The word address starts at 0 for every load frame and rises by one for each following write.
- R5: A frame whose decoded content is exactly the byte 0x02 (start) plus its CRC gives a one-cycle `start_pulse`, in the cycle after the delimiter is sampled, when `engine_busy` is low at that delimiter.
- R6: A start frame whose delimiter arrives while `engine_busy` is high produces no pulse.
- R7: The last decoded byte is a CRC-8 (polynomial 0x07, initial value 0, no reflection, no final XOR) over all earlier decoded bytes. A frame that fails this check causes no write and no pulse.
- R8: A frame with a message type other than 0x01 or 0x02 is discarded.
- R9: A code byte of 0xFF is followed by 254 data bytes with no implied zero, so a load of 64 words made only of non-zero bytes is still written correctly.
- R10: A frame whose delimiter arrives before the data bytes announced by the last code byte is discarded.
- R11: A load frame is discarded if its payload is not a multiple of 4 bytes or exceeds `WORDS` words. A start frame that carries payload bytes is also discarded.
- R12: Consecutive zero bytes (empty frames) cause no write and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the engine |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| engine_busy | input | 1 | Engine is executing; start requests are dropped |
| ram_we | output | 1 | Instruction memory write enable |
| ram_addr | output | AW | Instruction memory word address |
| ram_wdata | output | 32 | Instruction word to write |
| start_pulse | output | 1 | One-cycle request to start the engine |

## Verification
Both results are timed from the clock edge that samples the delimiter byte. The start pulse is due exactly one cycle after that edge, and the word at address n is due n+1 cycles after it. The monitor resets a cycle count whenever it sees a delimiter on the input and compares that count with the address of each write, or with zero for a pulse, so an early or late result fails as surely as a wrong value. Each discard case closes with a check that the expected queues are empty and that no unexpected write or pulse appeared, before the next frame is sent.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_BODY,
        ST_SKIP,
        ST_COMMIT
    } ldr_state_e;

    localparam logic [7:0] MSG_LOAD = 8'h01;
    localparam logic [7:0] MSG_START = 8'h02;
    localparam logic [7:0] CRC_POLY = 8'h07;

    // One byte of an MSB-first CRC-8 with zero initial value
    function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] din);
        logic [7:0] r;
        r = acc ^ din;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ({r[6:0], 1'b0} ^ CRC_POLY) : {r[6:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/ldr_cobs_rx.sv
// COBS byte decoder: at most one decoded byte per input byte.
module ldr_cobs_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       dec_valid,
    output logic [7:0] dec_byte,
    output logic       frm_start,
    output logic       frm_end,
    output logic       frm_short
);

    logic       in_frame;
    logic [7:0] left;
    logic       no_fill;
    logic       take;

    assign take = en && in_valid;

    always_comb begin
        dec_valid = 1'b0;
        dec_byte  = 8'h00;
        frm_start = 1'b0;
        frm_end   = 1'b0;
        frm_short = 1'b0;
        if (take) begin
            if (in_byte == 8'h00) begin
                // R2: delimiter closes the frame; R10: data still owed
                frm_end   = in_frame;
                frm_short = in_frame && (left != 8'h00);
            end else if (!in_frame) begin
                frm_start = 1'b1;
            end else if (left == 8'h00) begin
                // R9: a 0xFF group carries no implied zero
                dec_valid = !no_fill;
                dec_byte  = 8'h00;
            end else begin
                dec_valid = 1'b1;
                dec_byte  = in_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            left     <= 8'h00;
            no_fill  <= 1'b0;
        end else if (take) begin
            if (in_byte == 8'h00) begin
                in_frame <= 1'b0;
                left     <= 8'h00;
            end else if (!in_frame || left == 8'h00) begin
                in_frame <= 1'b1;
                left     <= in_byte - 8'h01;
                no_fill  <= (in_byte == 8'hFF);
            end else begin
                left <= left - 8'h01;
            end
        end
    end

    // R2
    decode_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> in_frame);

endmodule

// File: rtl/ldr_crc8.sv
// Running CRC-8 over decoded bytes; residue is zero after a correct trailer.
module ldr_crc8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import ldr_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 8'h00;
        end else if (clr) begin
            crc <= 8'h00;
        end else if (upd) begin
            crc <= crc8_step(crc, din);
        end
    end

endmodule

// File: rtl/ldr_stage.sv
// Byte-wide staging store with a little-endian word read port.
module ldr_stage #(
    parameter int WORDS = 64,
    localparam int CAP = 4 * WORDS,
    localparam int BW = $clog2(CAP),
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_idx,
    output logic [31:0]   rd_word
);

    logic [7:0] mem [CAP];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_byte;
        end
    end

    // R3: byte lane l of word n holds payload byte 4n+l
    for (genvar l = 0; l < 4; l++) begin : g_lane
        assign rd_word[8*l +: 8] = mem[{rd_idx, 2'(l)}];
    end

endmodule

// File: rtl/cobs_prog_loader.sv
module cobs_prog_loader #(
    parameter int WORDS = 64,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          engine_busy,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [31:0]   ram_wdata,
    output logic          start_pulse
);
    import ldr_pkg::*;

    localparam int CAP = 4 * WORDS;
    localparam int BW = $clog2(CAP);
    localparam int CW = $clog2(CAP + 4);
    localparam int NW = AW + 1;

    ldr_state_e    state, state_nx;
    logic [7:0]    msg_type;
    logic [CW-1:0] dec_cnt;
    logic [NW-1:0] n_words;
    logic [AW-1:0] cidx;
    logic          start_q;

    logic          dec_valid, frm_start, frm_end, frm_short;
    logic [7:0]    dec_byte;
    logic [7:0]    crc;
    logic [31:0]   stage_word;
    logic          st_wr;
    logic [BW-1:0] st_idx;

    logic [CW-1:0] pay_len;
    logic          frame_good, load_ok, start_ok, overflow;
    logic [NW-1:0] load_words;

    ldr_cobs_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state != ST_COMMIT),
        .in_valid (rx_valid),
        .in_byte  (rx_byte),
        .dec_valid(dec_valid),
        .dec_byte (dec_byte),
        .frm_start(frm_start),
        .frm_end  (frm_end),
        .frm_short(frm_short)
    );

    ldr_crc8 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (frm_start),
        .upd  (dec_valid),
        .din  (dec_byte),
        .crc  (crc)
    );

    ldr_stage #(.WORDS(WORDS)) u_stage (
        .clk    (clk),
        .wr_en  (st_wr),
        .wr_idx (st_idx),
        .wr_byte(dec_byte),
        .rd_idx (cidx),
        .rd_word(stage_word)
    );

    // Byte after the type goes to stage index dec_cnt-1; the trailer may land too
    assign st_wr  = (state == ST_BODY) && dec_valid && (dec_cnt != '0) && (dec_cnt <= CW'(CAP));
    assign st_idx = BW'(dec_cnt - CW'(1));

    // R11: more than type + CAP payload + trailer bytes
    assign overflow = (state == ST_BODY) && dec_valid && (dec_cnt >= CW'(CAP + 2));

    // Frame verdict at the delimiter
    assign pay_len    = dec_cnt - CW'(2);
    assign load_words = NW'(pay_len >> 2);
    always_comb begin
        // R7, R10
        frame_good = !frm_short && (dec_cnt >= CW'(2)) && (crc == 8'h00);
        // R3, R8, R11
        load_ok    = frame_good && (msg_type == MSG_LOAD) && (pay_len[1:0] == 2'b00);
        // R5, R8, R11
        start_ok   = frame_good && (msg_type == MSG_START) && (dec_cnt == CW'(2));
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: begin
                if (frm_start) state_nx = ST_BODY;
            end
            ST_BODY: begin
                if (frm_end) begin
                    state_nx = (load_ok && load_words != '0) ? ST_COMMIT : ST_HUNT;
                end else if (overflow) begin
                    state_nx = ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (frm_end) state_nx = ST_HUNT;
            end
            ST_COMMIT: begin
                if (cidx == AW'(n_words - NW'(1))) state_nx = ST_HUNT;
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // Frame bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_type <= 8'h00;
            dec_cnt  <= '0;
            n_words  <= '0;
            cidx     <= '0;
            start_q  <= 1'b0;
        end else begin
            start_q <= (state == ST_BODY) && frm_end && start_ok && !engine_busy;
            if (frm_start) begin
                dec_cnt <= '0;
            end else if (state == ST_BODY && dec_valid) begin
                dec_cnt <= dec_cnt + CW'(1);
                if (dec_cnt == '0) msg_type <= dec_byte;
            end
            if (state == ST_BODY && frm_end) begin
                n_words <= load_words;
                cidx    <= '0;
            end else if (state == ST_COMMIT) begin
                cidx <= cidx + AW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        ram_we      = (state == ST_COMMIT);
        ram_addr    = cidx;
        ram_wdata   = stage_word;
        start_pulse = start_q;
    end

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == AW'($past(ram_addr) + AW'(1))));

    // R3
    commit_after_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> $past(rx_valid && rx_byte == 8'h00));

    // R3
    first_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> (ram_addr == '0));

    // R6
    busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !$past(engine_busy));

    // R5
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R5
    start_after_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(rx_valid && rx_byte == 8'h00));

endmodule

// File: tb/cobs_prog_loader_tb.sv
`timescale 1ns/1ps
module cobs_prog_loader_tb;

    localparam int WORDS = 64;
    localparam int AW = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          engine_busy = 1'b0;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [31:0]   ram_wdata;
    logic          start_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          addr;
        logic [31:0] data;
        string       tag;
    } wr_item_t;

    wr_item_t wr_q[$];
    string    st_q[$];
    int       since = 1000;

    always #2.5 clk = ~clk;

    cobs_prog_loader #(.WORDS(WORDS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .engine_busy(engine_busy),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .start_pulse(start_pulse)
    );

    // Monitor: pops expected results and checks value and timing
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ram_we) begin
                checks++;
                if (wr_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected write: actual addr=%0d data=%h, expected none",
                             ram_addr, ram_wdata);
                end else begin
                    wr_item_t it;
                    it = wr_q.pop_front();
                    if (int'(ram_addr) != it.addr || ram_wdata !== it.data || since != it.addr) begin
                        errors++;
                        $display("FAIL %s write: actual addr=%0d data=%h lag=%0d, expected addr=%0d data=%h lag=%0d",
                                 it.tag, ram_addr, ram_wdata, since, it.addr, it.data, it.addr);
                    end
                end
            end
            if (start_pulse) begin
                checks++;
                if (st_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected start pulse: actual 1, expected 0 (lag=%0d)", since);
                end else begin
                    string tg;
                    tg = st_q.pop_front();
                    if (since != 0) begin
                        errors++;
                        $display("FAIL %s start timing: actual lag=%0d, expected lag=0", tg, since);
                    end
                end
            end
            if (rx_valid && rx_byte == 8'h00) since = 0;
            else since = since + 1;
        end
    end

    function automatic logic [7:0] crc8_q(input logic [7:0] d[$]);
        logic [7:0] c;
        c = 8'h00;
        foreach (d[i]) begin
            c = c ^ d[i];
            for (int k = 0; k < 8; k++) begin
                c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
            end
        end
        return c;
    endfunction

    task automatic make_msg(input logic [7:0] typ, input logic [7:0] pl[$],
                            input logic [7:0] cx, output logic [7:0] m[$]);
        m = {};
        m.push_back(typ);
        foreach (pl[i]) m.push_back(pl[i]);
        m.push_back(crc8_q(m) ^ cx);
    endtask

    task automatic w2b(input logic [31:0] w[$], output logic [7:0] b[$]);
        b = {};
        foreach (w[i]) begin
            for (int l = 0; l < 4; l++) b.push_back(w[i][8*l +: 8]);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk);
        #1;
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    task automatic settle();
        repeat (WORDS + 8) @(posedge clk);
    endtask

    // COBS-encode the decoded content and send it with its delimiter
    task automatic send_frame(input logic [7:0] d[$]);
        logic [7:0] blk[$];
        logic [7:0] outq[$];
        blk = {};
        outq = {};
        foreach (d[i]) begin
            if (d[i] == 8'h00) begin
                outq.push_back(8'(blk.size() + 1));
                foreach (blk[j]) outq.push_back(blk[j]);
                blk = {};
            end else begin
                blk.push_back(d[i]);
                if (blk.size() == 254) begin
                    outq.push_back(8'hFF);
                    foreach (blk[j]) outq.push_back(blk[j]);
                    blk = {};
                end
            end
        end
        outq.push_back(8'(blk.size() + 1));
        foreach (blk[j]) outq.push_back(blk[j]);
        foreach (outq[i]) send_byte(outq[i]);
        send_byte(8'h00);
        settle();
    endtask

    task automatic expect_words(input logic [31:0] w[$], input string tag);
        foreach (w[i]) begin
            wr_item_t it;
            it.addr = i;
            it.data = w[i];
            it.tag  = tag;
            wr_q.push_back(it);
        end
    endtask

    task automatic check_drained(input string tag);
        checks++;
        if (wr_q.size() != 0 || st_q.size() != 0) begin
            errors++;
            $display("FAIL %s: actual %0d writes and %0d pulses outstanding, expected 0 and 0",
                     tag, wr_q.size(), st_q.size());
        end
        wr_q = {};
        st_q = {};
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] w[$];
        logic [7:0]  pl[$];
        logic [7:0]  m[$];

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle outputs after reset
        checks++;
        if (ram_we !== 1'b0 || start_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual we=%b start=%b, expected 0 0", ram_we, start_pulse);
        end

        // R2, R3: load with embedded zero bytes (implied zeros)
        w = '{32'h00A1_00B2, 32'h0000_0000, 32'hDEAD_BE00};
        expect_words(w, "R2/R3 load");
        w2b(w, pl);
        make_msg(8'h01, pl, 8'h00, m);
        send_frame(m);
        check_drained("R3 load drained");

        // R5: start while engine idle
        st_q.push_back("R5 start");
        pl = {};
        make_msg(8'h02, pl, 8'h00, m);
        send_frame(m);
        check_drained("R5 start drained");

        // R6: start while engine busy
        engine_busy = 1'b1;
        make_msg(8'h02, pl, 8'h00, m);
        send_frame(m);
        engine_busy = 1'b0;
        check_drained("R6 busy start ignored");

        // R7: corrupted CRC
        w = '{32'h1234_5678, 32'h9ABC_DEF0};
        w2b(w, pl);
        make_msg(8'h01, pl, 8'h5A, m);
        send_frame(m);
        check_drained("R7 bad crc ignored");

        // R8: unknown message type
        pl = '{8'h11, 8'h22, 8'h33, 8'h44};
        make_msg(8'h05, pl, 8'h00, m);
        send_frame(m);
        check_drained("R8 unknown type ignored");

        // R4: second load restarts at address 0
        w = '{32'hCAFE_F00D, 32'h0102_0304};
        expect_words(w, "R4 reload");
        w2b(w, pl);
        make_msg(8'h01, pl, 8'h00, m);
        send_frame(m);
        check_drained("R4 reload drained");

        // R9: full-size load of non-zero bytes uses a 0xFF code group
        w = {};
        for (int i = 0; i < WORDS; i++) w.push_back(32'h1122_3344 + 32'(i) * 32'h0101_0101);
        expect_words(w, "R9 full load");
        w2b(w, pl);
        make_msg(8'h01, pl, 8'h00, m);
        send_frame(m);
        check_drained("R9 full load drained");

        // R10: truncated frame (code announces 4 data bytes, 2 arrive)
        pl = '{8'h02};
        send_byte(8'h05);
        send_byte(8'h02);
        send_byte(crc8_q(pl));
        send_byte(8'h00);
        settle();
        check_drained("R10 truncated ignored");

        // R11: payload not a multiple of 4
        pl = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60};
        make_msg(8'h01, pl, 8'h00, m);
        send_frame(m);
        check_drained("R11 ragged load ignored");

        // R11: one word too many
        w = {};
        for (int i = 0; i < WORDS + 1; i++) w.push_back(32'h0505_0505 + 32'(i));
        w2b(w, pl);
        make_msg(8'h01, pl, 8'h00, m);
        send_frame(m);
        check_drained("R11 oversize load ignored");

        // R11: start carrying a payload byte
        pl = '{8'hAA};
        make_msg(8'h02, pl, 8'h00, m);
        send_frame(m);
        check_drained("R11 long start ignored");

        // R12: empty frames
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h00);
        settle();
        check_drained("R12 empty frames ignored");

        // R5: loader still accepts a start after all discarded frames
        st_q.push_back("R5 start after errors");
        pl = {};
        make_msg(8'h02, pl, 8'h00, m);
        send_frame(m);
        check_drained("R5 late start drained");

        finish_up();
    end

endmodule